// File: doc/BRIEF.md
# Tag-Propagating Logic Operator Unit

This unit is shadow logic for information-flow tracking. Each operand is one logic bit paired with a vector of N tag bits. Each tag bit records that the value may depend on some labelled source. The unit applies a two-input operation to the logic values. In the same step it decides which tags survive into the result, using the operation, the other operand's current value and a fixed grouping of tags.

Three things decide which tags survive:

- **Blocking by value.** For AND and OR, a tag is dropped when the other operand's value already fixes the result. XOR and unmodelled operations forward every tag.
- **Tag groups.** A compile-time map assigns each tag index a group. A tag in one group cannot be blocked by an operand that carries a tag of that same group.
- **Tag editing and queries.** Two extra operations work on a single tag chosen by index. One adds or removes that tag. The other asks whether that tag is present.

An output register, chosen by parameter and on by default, holds the result. It loads only on cycles marked valid.

Top module: `tagflow_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `y_val` and `y_tags` to zero at the next rising edge.
- R2: When `in_valid` is 1 at a rising edge, the result appears on `y_val`/`y_tags` after that edge and `out_valid` is 1. When `in_valid` is 0, `out_valid` drops to 0 and `y_val`/`y_tags` keep their last values.
- R3: AND is selected with `op_sel` = 0. `y_val` is `a_val & b_val`. A tag on one operand reaches `y_tags` when the other operand's value is 1, or when R7 applies.
- R4: OR is selected with `op_sel` = 1. `y_val` is `a_val | b_val`. A tag on one operand reaches `y_tags` when the other operand's value is 0, or when R7 applies.
- R5: XOR is selected with `op_sel` = 2. `y_val` is `a_val ^ b_val`. `y_tags` is the union of both tag vectors for any operand values. This still holds when both operands carry the same tag.
- R6: The unmodelled operation is selected with `op_sel` = 3. The unused codes 6 and 7 behave the same way. `y_val` is `a_val` and `y_tags` is the union of both tag vectors.
- R7: Tag i belongs to group `GROUP_MAP[i*GW +: GW]`. By default, tags 0 and 1 form group 0 and tags 2 and 3 form group 1. Under AND or OR, a tag passes despite a blocking operand value when the blocking operand carries any tag of the same group. Tags of other groups on that operand stay blocked.
- R8: Set/clear is selected with `op_sel` = 4. `y_val` is `a_val`. Every tag of `a_tags` except index `tag_idx` passes unchanged. That tag is forced to 1 when `set_en` is 1. Otherwise it is forced to 0 when `clr_en` is 1. Otherwise it keeps its value from `a_tags`. Operand b has no effect.
- R9: Query is selected with `op_sel` = 5. `y_val` is bit `tag_idx` of `a_tags` and `y_tags` is all zero. `a_val` and operand b have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 3 | Operation code |
| a_val | input | 1 | Logic value of operand A |
| a_tags | input | N | Tag vector of operand A |
| b_val | input | 1 | Logic value of operand B |
| b_tags | input | N | Tag vector of operand B |
| tag_idx | input | IW | Tag chosen for set/clear and query |
| set_en | input | 1 | Add the chosen tag (wins over clr_en) |
| clr_en | input | 1 | Remove the chosen tag |
| out_valid | output | 1 | Result on y_val/y_tags was loaded last cycle |
| y_val | output | 1 | Result logic value |
| y_tags | output | N | Result tag vector |

## Verification
AND and OR are driven with each blocking value against tags in the same group and in different groups. This separates plain value-based blocking from the group rule, and it shows that a blocked tag from a foreign group stays out. XOR runs with both operands carrying the same tag, to confirm that no cancellation is assumed. The set/clear cases combine set and clear to expose the priority order. The query cases use a logic value opposite to the tag bit, so an output that followed the value would be caught. A long run of random operands and codes, including the two unused codes, is checked against an independent model. Idle gaps and a mid-run reset confirm that results hold and clear as required.

// File: rtl/tagflow_pkg.sv
package tagflow_pkg;

    typedef enum logic [2:0] {
        TF_AND     = 3'd0,
        TF_OR      = 3'd1,
        TF_XOR     = 3'd2,
        TF_UNKNOWN = 3'd3,
        TF_SET_TAG = 3'd4,
        TF_GET_TAG = 3'd5
    } tf_op_e;

    typedef struct packed {
        logic set_en;
        logic clr_en;
    } tf_edit_t;

    // Map the raw select onto an operation; spare codes fall back to worst case.
    function automatic tf_op_e decode_op(input logic [2:0] sel);
        case (sel)
            3'd0:    return TF_AND;
            3'd1:    return TF_OR;
            3'd2:    return TF_XOR;
            3'd4:    return TF_SET_TAG;
            3'd5:    return TF_GET_TAG;
            default: return TF_UNKNOWN;
        endcase
    endfunction

    // True when an operand with value v masks the other operand under op.
    function automatic logic masks_partner(input tf_op_e op, input logic v);
        case (op)
            TF_AND:  return ~v;
            TF_OR:   return v;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tf_group_screen.sv
module tf_group_screen #(
    parameter int N = 4,
    parameter int GW = 2,
    parameter logic [N*GW-1:0] GROUP_MAP = '0
) (
    input  logic [N-1:0] partner_tags,
    output logic [N-1:0] kin_present
);
    // kin_present[i]: partner carries some tag sharing tag i's group.
    for (genvar i = 0; i < N; i++) begin : g_tag
        logic [N-1:0] same_grp;
        for (genvar j = 0; j < N; j++) begin : g_cmp
            assign same_grp[j] = partner_tags[j] &&
                (GROUP_MAP[j*GW +: GW] == GROUP_MAP[i*GW +: GW]);
        end
        assign kin_present[i] = |same_grp;
    end
endmodule

// File: rtl/tf_tag_edit.sv
module tf_tag_edit
    import tagflow_pkg::*;
#(
    parameter int N = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  tags_in,
    input  logic [IW-1:0] idx,
    input  tf_edit_t      ctl,
    output logic [N-1:0]  tags_out,
    output logic          picked
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = (idx == IW'(i));
    end

    always_comb begin
        if (ctl.set_en)
            tags_out = tags_in | hit;
        else if (ctl.clr_en)
            tags_out = tags_in & ~hit;
        else
            tags_out = tags_in;
    end

    assign picked = |(tags_in & hit);
endmodule

// File: rtl/tf_core.sv
module tf_core
    import tagflow_pkg::*;
#(
    parameter int N = 4,
    parameter int GW = 2,
    parameter logic [N*GW-1:0] GROUP_MAP = '0,
    parameter int IW = 2
) (
    input  logic [2:0]    op_sel,
    input  logic          a_val,
    input  logic [N-1:0]  a_tags,
    input  logic          b_val,
    input  logic [N-1:0]  b_tags,
    input  logic [IW-1:0] tag_idx,
    input  tf_edit_t      edit,
    output logic          r_val,
    output logic [N-1:0]  r_tags
);
    tf_op_e       op;
    logic [N-1:0] a_kin, b_kin;
    logic [N-1:0] a_keep, b_keep;
    logic [N-1:0] edited;
    logic         picked;

    assign op = decode_op(op_sel);

    // a_kin[i]: b holds a tag in the group of a's tag i (and vice versa).
    tf_group_screen #(.N(N), .GW(GW), .GROUP_MAP(GROUP_MAP)) u_screen_a (
        .partner_tags (b_tags),
        .kin_present  (a_kin)
    );

    tf_group_screen #(.N(N), .GW(GW), .GROUP_MAP(GROUP_MAP)) u_screen_b (
        .partner_tags (a_tags),
        .kin_present  (b_kin)
    );

    tf_tag_edit #(.N(N), .IW(IW)) u_edit (
        .tags_in  (a_tags),
        .idx      (tag_idx),
        .ctl      (edit),
        .tags_out (edited),
        .picked   (picked)
    );

    // A tag survives unless the partner masks it and holds no kin tag.
    assign a_keep = a_tags & ~({N{masks_partner(op, b_val)}} & ~a_kin);
    assign b_keep = b_tags & ~({N{masks_partner(op, a_val)}} & ~b_kin);

    always_comb begin
        r_tags = a_keep | b_keep;
        case (op)
            TF_AND:     r_val = a_val & b_val;
            TF_OR:      r_val = a_val | b_val;
            TF_XOR:     r_val = a_val ^ b_val;
            TF_SET_TAG: begin
                r_val  = a_val;
                r_tags = edited;
            end
            TF_GET_TAG: begin
                r_val  = picked;
                r_tags = '0;
            end
            default:    r_val = a_val;
        endcase
    end
endmodule

// File: rtl/tf_out_stage.sv
module tf_out_stage #(
    parameter int N = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         d_val,
    input  logic [N-1:0] d_tags,
    output logic         out_valid,
    output logic         q_val,
    output logic [N-1:0] q_tags
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                q_val     <= 1'b0;
                q_tags    <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    q_val  <= d_val;
                    q_tags <= d_tags;
                end
            end
        end
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign out_valid  = in_valid;
        assign q_val      = d_val;
        assign q_tags     = d_tags;
    end
endmodule

// File: rtl/tagflow_unit.sv
module tagflow_unit
    import tagflow_pkg::*;
#(
    parameter int N = 4,
    parameter int GW = 2,
    parameter logic [N*GW-1:0] GROUP_MAP = 8'b01_01_00_00,
    parameter bit REG_OUT = 1'b1,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    op_sel,
    input  logic          a_val,
    input  logic [N-1:0]  a_tags,
    input  logic          b_val,
    input  logic [N-1:0]  b_tags,
    input  logic [IW-1:0] tag_idx,
    input  logic          set_en,
    input  logic          clr_en,
    output logic          out_valid,
    output logic          y_val,
    output logic [N-1:0]  y_tags
);
    tf_edit_t     edit;
    logic         r_val;
    logic [N-1:0] r_tags;

    assign edit = '{set_en: set_en, clr_en: clr_en};

    tf_core #(.N(N), .GW(GW), .GROUP_MAP(GROUP_MAP), .IW(IW)) u_core (
        .op_sel  (op_sel),
        .a_val   (a_val),
        .a_tags  (a_tags),
        .b_val   (b_val),
        .b_tags  (b_tags),
        .tag_idx (tag_idx),
        .edit    (edit),
        .r_val   (r_val),
        .r_tags  (r_tags)
    );

    tf_out_stage #(.N(N), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .d_val     (r_val),
        .d_tags    (r_tags),
        .out_valid (out_valid),
        .q_val     (y_val),
        .q_tags    (y_tags)
    );
endmodule

// File: rtl/tagflow_unit_chk.sv
module tagflow_unit_chk #(
    parameter int N = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [2:0]   op_sel,
    input logic         a_val,
    input logic [N-1:0] a_tags,
    input logic         b_val,
    input logic [N-1:0] b_tags,
    input logic         out_valid,
    input logic         y_val,
    input logic [N-1:0] y_tags
);
    if (REG_OUT) begin : g_seq
        // R1
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (!out_valid && !y_val && y_tags == '0));

        // R2
        valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

        // R2
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!out_valid && $stable(y_val) && $stable(y_tags)));

        // R3
        and_value_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 3'd0) |=> (y_val == $past(a_val & b_val)));

        // R5
        xor_union_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 3'd2) |=> (y_tags == $past(a_tags | b_tags)));

        // R6
        unknown_union_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 3'd3) |=> (y_tags == $past(a_tags | b_tags)));

        // R8
        set_value_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 3'd4) |=> (y_val == $past(a_val)));

        // R9
        get_empty_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 3'd5) |=> (y_tags == '0));
    end
endmodule

bind tagflow_unit tagflow_unit_chk #(.N(N), .REG_OUT(REG_OUT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .a_val     (a_val),
    .a_tags    (a_tags),
    .b_val     (b_val),
    .b_tags    (b_tags),
    .out_valid (out_valid),
    .y_val     (y_val),
    .y_tags    (y_tags)
);

// File: tb/tagflow_unit_tb_top.sv
module tagflow_unit_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   op_sel = '0;
    logic         a_val = 1'b0, b_val = 1'b0;
    logic [N-1:0] a_tags = '0, b_tags = '0;
    logic [1:0]   tag_idx = '0;
    logic         set_en = 1'b0, clr_en = 1'b0;
    logic         out_valid, y_val;
    logic [N-1:0] y_tags;

    typedef struct {
        logic         v;
        logic [N-1:0] t;
        string        req;
    } exp_t;

    exp_t         sb_q[$];
    int           n_run = 0;
    int           n_fail = 0;
    logic         last_v = 1'b0;
    logic [N-1:0] last_t = '0;
    bit           have_last = 1'b0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    tagflow_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .a_val(a_val), .a_tags(a_tags), .b_val(b_val), .b_tags(b_tags),
        .tag_idx(tag_idx), .set_en(set_en), .clr_en(clr_en),
        .out_valid(out_valid), .y_val(y_val), .y_tags(y_tags)
    );

    task automatic check(input bit ok, input string req,
                         input logic [N:0] act, input logic [N:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual={v,tags}=%b expected=%b", req, act, exp);
        end
    endtask

    // Bench model: tags 0,1 in group 0, tags 2,3 in group 1.
    function automatic bit kin(input logic [N-1:0] partner, input int i);
        for (int j = 0; j < N; j++)
            if (partner[j] && (j / 2) == (i / 2)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [N:0] model(input logic [2:0] op, input logic av,
            input logic [N-1:0] at, input logic bv, input logic [N-1:0] bt,
            input logic [1:0] idx, input logic s, input logic c);
        logic         v;
        logic [N-1:0] t;
        t = '0;
        case (op)
            3'd0, 3'd1: begin
                v = (op == 3'd0) ? (av & bv) : (av | bv);
                for (int i = 0; i < N; i++) begin
                    bit a_open, b_open;
                    a_open = ((op == 3'd0) ? bv : !bv) || kin(bt, i);
                    b_open = ((op == 3'd0) ? av : !av) || kin(at, i);
                    t[i] = (at[i] && a_open) || (bt[i] && b_open);
                end
            end
            3'd2: begin v = av ^ bv; t = at | bt; end
            3'd4: begin
                v = av; t = at;
                if (s) t[idx] = 1'b1;
                else if (c) t[idx] = 1'b0;
            end
            3'd5: begin v = at[idx]; t = '0; end
            default: begin v = av; t = at | bt; end
        endcase
        return {v, t};
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3/R7";
            3'd1: return "R4/R7";
            3'd2: return "R5";
            3'd4: return "R8";
            3'd5: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic drive(input logic [2:0] op, input logic av, input logic [N-1:0] at,
                         input logic bv, input logic [N-1:0] bt, input logic [1:0] idx,
                         input logic s, input logic c, input string req);
        exp_t e;
        logic [N:0] m;
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; a_val = av; a_tags = at;
        b_val = bv; b_tags = bt; tag_idx = idx; set_en = s; clr_en = c;
        m = model(op, av, at, bv, bt, idx, s, c);
        e.v = m[N]; e.t = m[N-1:0]; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a_val = ~a_val; a_tags = ~a_tags; b_tags = ~b_tags;
        end
    endtask

    // Monitor: compare results against the scoreboard; check holding when idle (R2).
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (out_valid) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R2 unexpected out_valid", {y_val, y_tags}, '0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check({y_val, y_tags} === {e.v, e.t}, e.req,
                              {y_val, y_tags}, {e.v, e.t});
                        last_v = e.v; last_t = e.t; have_last = 1'b1;
                    end
                end else if (have_last) begin
                    check({y_val, y_tags} === {last_v, last_t}, "R2 hold",
                          {y_val, y_tags}, {last_v, last_t});
                end
            end
        end
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check({out_valid, y_val, y_tags} === '0, "R1 reset",
              {y_val, y_tags}, '0);
        @(negedge clk);
        rst = 1'b0;
        have_last = 1'b1; last_v = 1'b0; last_t = '0;

        // R3 AND, value-based blocking
        drive(3'd0, 1'b1, 4'b0010, 1'b1, 4'b1000, 2'd0, 1'b0, 1'b0, "R3 and both one");
        drive(3'd0, 1'b0, 4'b0001, 1'b1, 4'b0100, 2'd0, 1'b0, 1'b0, "R3 and a zero blocks b");
        // R4 OR
        drive(3'd4 - 3'd3, 1'b1, 4'b0001, 1'b0, 4'b0100, 2'd0, 1'b0, 1'b0, "R4 or a one blocks b");
        drive(3'd1, 1'b0, 4'b0010, 1'b0, 4'b1000, 2'd0, 1'b0, 1'b0, "R4 or both zero");
        // R5 XOR, union and no cancellation
        drive(3'd2, 1'b1, 4'b0011, 1'b1, 4'b1100, 2'd0, 1'b0, 1'b0, "R5 xor union");
        drive(3'd2, 1'b1, 4'b0100, 1'b1, 4'b0100, 2'd0, 1'b0, 1'b0, "R5 xor same tag");
        // R6 unmodelled and spare codes
        drive(3'd3, 1'b0, 4'b0001, 1'b1, 4'b1000, 2'd0, 1'b0, 1'b0, "R6 unknown");
        drive(3'd6, 1'b1, 4'b0010, 1'b0, 4'b0100, 2'd0, 1'b0, 1'b0, "R6 code6");
        drive(3'd7, 1'b0, 4'b0000, 1'b1, 4'b1001, 2'd0, 1'b0, 1'b0, "R6 code7");
        // R7 groups: kin unblocks, foreign group stays blocked
        drive(3'd0, 1'b0, 4'b0101, 1'b0, 4'b0010, 2'd0, 1'b0, 1'b0, "R7 and group");
        drive(3'd1, 1'b1, 4'b1000, 1'b1, 4'b0100, 2'd0, 1'b0, 1'b0, "R7 or group");
        drive(3'd0, 1'b0, 4'b0001, 1'b0, 4'b0100, 2'd0, 1'b0, 1'b0, "R7 and foreign");
        // R8 set/clear and priority
        drive(3'd4, 1'b1, 4'b0001, 1'b0, 4'b1111, 2'd2, 1'b1, 1'b1, "R8 set wins");
        drive(3'd4, 1'b0, 4'b0011, 1'b1, 4'b1111, 2'd0, 1'b0, 1'b1, "R8 clear");
        drive(3'd4, 1'b1, 4'b1010, 1'b1, 4'b0101, 2'd3, 1'b0, 1'b0, "R8 keep");
        // R9 query ignores a_val
        drive(3'd5, 1'b0, 4'b0010, 1'b0, 4'b1111, 2'd1, 1'b0, 1'b0, "R9 get present");
        drive(3'd5, 1'b1, 4'b0111, 1'b1, 4'b1000, 2'd3, 1'b0, 1'b0, "R9 get absent");
        idle(3);

        for (int k = 0; k < 400; k++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            drive(op, 1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
                  2'($urandom), 1'($urandom), 1'($urandom), req_of(op));
            if (($urandom % 8) == 0) idle(1);
        end
        idle(3);

        // R1: reset after results clears outputs
        drive(3'd2, 1'b1, 4'b1111, 1'b0, 4'b0000, 2'd0, 1'b0, 1'b0, "R5 pre-reset");
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check({out_valid, y_val, y_tags} === '0, "R1 mid-run reset",
              {y_val, y_tags}, '0);
        last_v = 1'b0; last_t = '0;
        rst = 1'b0;
        idle(2);

        check(sb_q.size() == 0, "R2 all results seen", N'(sb_q.size()), '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule